// File: doc/BRIEF.md
# Banked GPIO Pin Configuration Registers

This block holds the configuration of a group of general-purpose I/O pads behind a narrow synchronous host port. Each pin owns exactly one byte address. Behind that address sit six internal four-bit banks and a per-pin bank pointer. A host byte with its top bit set stores a payload into the bank named in the byte. A host byte with its top bit clear only moves the pointer. A later read of the same address returns the pointed-to bank, tagged with its index.

The stored fields are decoded continuously into pad controls:
- output enable and output data, with open-drain handling
- input enable and tristate
- pull-up and pull-down selection with a pull-up strength code
- drive strength, function select and supply select
- an enable flag
- an optional inversion of the pad input on its way into the core

Pin count and base address are parameters.

Top module: `gpio_bank_regs`

## Requirements
- R1: Pin n (0 <= n < NUM_PINS) answers at address BASE_ADDR + n, with BASE_ADDR = 0x150 by default. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: A written byte is decoded as follows: bit 7 is the store flag, bits 6:4 are the bank index and bits 3:0 are the payload. With bit 7 set and an index of 0 to 5, the payload replaces that bank of the addressed pin, and the pin's bank pointer is left unchanged.
- R3: A written byte with bit 7 clear loads bits 6:4 into the pin's bank pointer and leaves every stored bank unchanged.
- R4: A read accepted on one clock edge presents, from the next edge on, {0, pointer[2:0], payload[3:0]} on bus_rdata. The payload is that of the pointed-to bank, or 0 when the pointer is 6 or 7. bus_rdata holds its value in cycles without a read.
- R5: When a read and a write are accepted in the same cycle, the read returns the state from before the write.
- R6: Bank 1 fields are: bits 3:2 mode (0 input, 1 both, 2 output, 3 off), bit 1 open-drain and bit 0 output value. In mode 1 or 2 with push-pull, pad_oe is 1 and pad_do equals the value. With open-drain, pad_oe is 1 only when the value is 0, and pad_do is always 0.
- R7: Bank 3 bit 0 (tristate) set, or mode 3, forces pad_oe and pad_ie to 0. Otherwise pad_ie is 1 in modes 0 and 1 and 0 in mode 2.
- R8: Bank 2 bits 3:1 hold the bias code. Codes 0 to 3 give pad_pu = 1 with pad_pu_str equal to the code. Code 4 gives pad_pd = 1. Codes 5, 6 and 7 give no pull. pad_pu_str is 0 whenever no pull-up is active.
- R9: pad_drv takes bank 3 bits 3:2. pad_func takes bank 4 bits 3:1. pad_vsel takes bank 0 bits 3:1, and pad_en takes bank 0 bit 0.
- R10: When bank 5 bit 3 is clear, core_in is the inverse of pad_in. When it is set, core_in equals pad_in.
- R11: A synchronous active-low reset clears every bank, every bank pointer and bus_rdata to zero.
- R12: A store (bit 7 set) naming bank 6 or 7 changes no stored state and does not move the bank pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte (store flag, bank index, payload) |
| bus_rdata | output | 8 | Registered read byte |
| pad_in | input | NUM_PINS | Pad input levels |
| core_in | output | NUM_PINS | Pad inputs after optional inversion |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_do | output | NUM_PINS | Pad output data |
| pad_ie | output | NUM_PINS | Pad input enable |
| pad_pu | output | NUM_PINS | Pull-up active |
| pad_pd | output | NUM_PINS | Pull-down active |
| pad_pu_str | output | 2*NUM_PINS | Pull-up strength code, 2 bits per pin |
| pad_drv | output | 2*NUM_PINS | Drive strength, 2 bits per pin |
| pad_func | output | 3*NUM_PINS | Function select, 3 bits per pin |
| pad_vsel | output | 3*NUM_PINS | Supply select, 3 bits per pin |
| pad_en | output | NUM_PINS | Pin enable flag |

## Verification
A read and a write can be accepted on the same edge. The write may even target the very bank the read points at. The bench provokes this directly with a store into the pointed-to bank in the read cycle, and expects the old payload, followed by the new one on the next read. A long stretch of random traffic also issues simultaneous reads and writes, including pointer moves and out-of-range addresses. The behavioural model resolves each such cycle by taking the read before applying the write, and every output is compared with the model after each clock.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the banked GPIO configuration block.
// Assumes a fixed six-bank, four-bit-payload register layout per pin.
package gpio_bank_pkg;
    localparam int NBANK     = 6;
    localparam int PAYLOAD_W = 4;
    localparam int IDX_W     = 3;

    typedef enum logic [1:0] {
        MODE_IN   = 2'd0,
        MODE_BOTH = 2'd1,
        MODE_OUT  = 2'd2,
        MODE_OFF  = 2'd3
    } pin_mode_e;

    localparam logic [2:0] BIAS_PULL_DOWN = 3'd4;

    typedef struct packed {
        logic       en;
        logic [2:0] vsel;
        logic       oe;
        logic       dout;
        logic       ie;
        logic       pu;
        logic       pd;
        logic [1:0] pu_str;
        logic [1:0] drv;
        logic [2:0] func;
        logic       inv;
    } pad_ctl_t;
endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
// Pure combinational decode of one pin's six banks into pad controls.
// Assumes banks are presented in index order, bank 0 lowest.
module gpio_bank_decode
    import gpio_bank_pkg::*;
(
    input  logic [NBANK-1:0][PAYLOAD_W-1:0] banks,
    input  logic                            pad_in,
    output pad_ctl_t                        ctl,
    output logic                            core_in
);
    pin_mode_e  mode;
    logic       open_drain;
    logic       out_val;
    logic       tristate;
    logic       driving;
    logic [2:0] bias;

    // Field extraction and pad control derivation
    always_comb begin
        mode       = pin_mode_e'(banks[1][3:2]);
        open_drain = banks[1][1];
        out_val    = banks[1][0];
        tristate   = banks[3][0];
        bias       = banks[2][3:1];
        driving    = (mode == MODE_BOTH || mode == MODE_OUT) && !tristate;

        ctl        = '0;
        ctl.en     = banks[0][0];
        ctl.vsel   = banks[0][3:1];
        ctl.oe     = driving && (!open_drain || !out_val);
        ctl.dout   = out_val && !open_drain;
        ctl.ie     = (mode == MODE_IN || mode == MODE_BOTH) && !tristate;
        ctl.pu     = !bias[2];
        ctl.pd     = (bias == BIAS_PULL_DOWN);
        ctl.pu_str = bias[2] ? 2'd0 : bias[1:0];
        ctl.drv    = banks[3][3:2];
        ctl.func   = banks[4][3:1];
        ctl.inv    = !banks[5][3];
        core_in    = pad_in ^ ctl.inv;
    end
endmodule

// File: rtl/gpio_bank_pin.sv
`timescale 1ns/1ps
// One pin's bank storage, bank pointer and read byte, plus its decode.
// Assumes wr_hit is already qualified by address match.
module gpio_bank_pin
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       pad_in,
    output logic [7:0] rd_byte,
    output pad_ctl_t   ctl,
    output logic       core_in
);
    logic [NBANK-1:0][PAYLOAD_W-1:0] bank_q;
    logic [IDX_W-1:0]                sel_q;
    logic [PAYLOAD_W-1:0]            sel_payload;

    wire             is_store = wdata[7];
    wire [IDX_W-1:0] w_idx    = wdata[6:4];

    // One register per bank, loaded by a store naming it
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (wr_hit && is_store && w_idx == IDX_W'(b))
                bank_q[b] <= wdata[PAYLOAD_W-1:0];
        end
    end

    // Bank pointer, moved only by a non-store write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_hit && !is_store)
            sel_q <= w_idx;
    end

    // Payload of the pointed-to bank, zero for indices past the last bank
    always_comb begin
        sel_payload = '0;
        for (int b = 0; b < NBANK; b++)
            if (sel_q == IDX_W'(b)) sel_payload = bank_q[b];
        rd_byte = {1'b0, sel_q, sel_payload};
    end

    gpio_bank_decode i_decode (
        .banks   (bank_q),
        .pad_in  (pad_in),
        .ctl     (ctl),
        .core_in (core_in)
    );

    // R3: pointer moves never disturb stored banks
    p_select_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && !wdata[7] |=> $stable(bank_q));
    // R2: stores never move the pointer
    p_store_keeps_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && wdata[7] |=> $stable(sel_q));
    // R12: stores to bank 6 or 7 are dropped
    p_bank67_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && wdata[7] && wdata[6:4] >= 3'd6 |=> $stable(bank_q));
    // R7: tristate or mode off silences both buffers
    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q[1][3:2] == 2'b11 || bank_q[3][0]) |-> (!ctl.oe && !ctl.ie));
    // R6: an open-drain pad never drives high
    p_od_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.oe && bank_q[1][1] |-> !ctl.dout);
    // R11: reset clears storage and pointer
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (bank_q == '0 && sel_q == '0));
endmodule

// File: rtl/gpio_bank_rdmux.sv
`timescale 1ns/1ps
// Registered read path: picks the addressed pin's read byte on a read.
// Assumes hit and idx come from the same address decode as the writes.
module gpio_bank_rdmux #(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd,
    input  logic                     hit,
    input  logic [PIN_W-1:0]         idx,
    input  logic [NUM_PINS-1:0][7:0] rd_bytes,
    output logic [7:0]               rdata
);
    logic [7:0] pick;

    // Select the addressed pin's byte
    always_comb begin
        pick = '0;
        for (int p = 0; p < NUM_PINS; p++)
            if (idx == PIN_W'(p)) pick = rd_bytes[p];
    end

    // Capture on read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= hit ? pick : 8'h00;
    end

    // R4: read data holds between reads
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    // R4: top bit of read data is always zero
    p_rd_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[7]);
    // R1: a read outside the pin range returns zero
    p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !hit |=> rdata == 8'h00);
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
// Top: address decode, per-pin bank registers, read mux and flattened
// pad controls. Assumes one bus access (read, write or both) per cycle.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h150
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]     pad_in,
    output logic [NUM_PINS-1:0]     core_in,
    output logic [NUM_PINS-1:0]     pad_oe,
    output logic [NUM_PINS-1:0]     pad_do,
    output logic [NUM_PINS-1:0]     pad_ie,
    output logic [NUM_PINS-1:0]     pad_pu,
    output logic [NUM_PINS-1:0]     pad_pd,
    output logic [2*NUM_PINS-1:0]   pad_pu_str,
    output logic [2*NUM_PINS-1:0]   pad_drv,
    output logic [3*NUM_PINS-1:0]   pad_func,
    output logic [3*NUM_PINS-1:0]   pad_vsel,
    output logic [NUM_PINS-1:0]     pad_en
);
    localparam int                PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] NP_A   = ADDR_W'(NUM_PINS);

    logic [ADDR_W-1:0]        offset;
    logic                     hit;
    logic [PIN_W-1:0]         pin_idx;
    logic [NUM_PINS-1:0][7:0] rd_bytes;
    pad_ctl_t                 ctl [NUM_PINS];

    // Map the bus address to a pin index and range hit
    always_comb begin
        offset  = bus_addr - BASE_A;
        hit     = (bus_addr >= BASE_A) && (offset < NP_A);
        pin_idx = offset[PIN_W-1:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_bank_pin i_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (bus_wr && hit && pin_idx == PIN_W'(p)),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[p]),
            .rd_byte (rd_bytes[p]),
            .ctl     (ctl[p]),
            .core_in (core_in[p])
        );

        assign pad_oe[p]            = ctl[p].oe;
        assign pad_do[p]            = ctl[p].dout;
        assign pad_ie[p]            = ctl[p].ie;
        assign pad_pu[p]            = ctl[p].pu;
        assign pad_pd[p]            = ctl[p].pd;
        assign pad_pu_str[2*p +: 2] = ctl[p].pu_str;
        assign pad_drv[2*p +: 2]    = ctl[p].drv;
        assign pad_func[3*p +: 3]   = ctl[p].func;
        assign pad_vsel[3*p +: 3]   = ctl[p].vsel;
        assign pad_en[p]            = ctl[p].en;

        // R8: pull-up and pull-down are never both active
        p_pull_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p]));
    end

    gpio_bank_rdmux #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .hit      (hit),
        .idx      (pin_idx),
        .rd_bytes (rd_bytes),
        .rdata    (bus_rdata)
    );
endmodule

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
    localparam int NP   = 8;
    localparam int BASE = 'h150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] core_in, pad_oe, pad_do, pad_ie, pad_pu, pad_pd, pad_en;
    logic [2*NP-1:0] pad_pu_str, pad_drv;
    logic [3*NP-1:0] pad_func, pad_vsel;

    int tests = 0, fails = 0;
    int mb [NP][6];
    int msel [NP];
    int mrd = 0;

    always #2.5 clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .pad_in, .core_in, .pad_oe, .pad_do, .pad_ie, .pad_pu, .pad_pd,
        .pad_pu_str, .pad_drv, .pad_func, .pad_vsel, .pad_en
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("[TB] FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model step: read sees old state, then the write applies
    task automatic model_step();
        int a, p, idx;
        a = int'(bus_addr);
        p = a - BASE;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                msel[i] = 0;
                for (int b = 0; b < 6; b++) mb[i][b] = 0;
            end
            mrd = 0;
            return;
        end
        if (bus_rd) begin
            if (p >= 0 && p < NP)
                mrd = (msel[p] << 4) | ((msel[p] < 6) ? mb[p][msel[p]] : 0);
            else
                mrd = 0;
        end
        if (bus_wr && p >= 0 && p < NP) begin
            idx = (bus_wdata >> 4) & 7;
            if (bus_wdata[7]) begin
                if (idx < 6) mb[p][idx] = bus_wdata & 15;
            end else
                msel[p] = idx;
        end
    endtask

    task automatic compare_all();
        int mode, od, v, dis, bias, inv;
        chk("R4 rdata", bus_rdata, mrd);
        for (int p = 0; p < NP; p++) begin
            mode = (mb[p][1] >> 2) & 3; od = (mb[p][1] >> 1) & 1; v = mb[p][1] & 1;
            dis  = mb[p][3] & 1;        bias = (mb[p][2] >> 1) & 7;
            inv  = ((mb[p][5] >> 3) & 1) ? 0 : 1;
            chk("R6 oe", pad_oe[p], ((mode == 1 || mode == 2) && !dis && (!od || !v)) ? 1 : 0);
            chk("R6 do", pad_do[p], od ? 0 : v);
            chk("R7 ie", pad_ie[p], ((mode == 0 || mode == 1) && !dis) ? 1 : 0);
            chk("R8 pu", pad_pu[p], (bias <= 3) ? 1 : 0);
            chk("R8 pd", pad_pd[p], (bias == 4) ? 1 : 0);
            chk("R8 pu_str", pad_pu_str[2*p +: 2], (bias <= 3) ? bias : 0);
            chk("R9 drv", pad_drv[2*p +: 2], (mb[p][3] >> 2) & 3);
            chk("R9 func", pad_func[3*p +: 3], (mb[p][4] >> 1) & 7);
            chk("R9 vsel", pad_vsel[3*p +: 3], (mb[p][0] >> 1) & 7);
            chk("R9 en", pad_en[p], mb[p][0] & 1);
            chk("R10 core_in", core_in[p], pad_in[p] ^ inv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int p, input int d);
        bus_addr = 10'(BASE + p); bus_wdata = 8'(d); bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 10'(a); bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("[TB] FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        chk("R11 rdata after reset", bus_rdata, 0);
        chk("R11 ie after reset", pad_ie[0], 1);
        rd(BASE, d); chk("R11 read pin0", d, 8'h00);

        // R6 push-pull output high
        wr(2, 8'h99);
        chk("R6 pp oe", pad_oe[2], 1); chk("R6 pp do", pad_do[2], 1);
        wr(2, 8'h10); rd(BASE + 2, d); chk("R3 select bank1 read", d, 8'h19);
        // R6 open-drain
        wr(2, 8'h9B); chk("R6 od high released", pad_oe[2], 0);
        wr(2, 8'h9A); chk("R6 od low oe", pad_oe[2], 1); chk("R6 od low do", pad_do[2], 0);
        // R7 tristate and mode off
        wr(2, 8'hB1); chk("R7 tristate oe", pad_oe[2], 0); chk("R7 tristate ie", pad_ie[2], 0);
        wr(2, 8'hB0); wr(2, 8'h9C); chk("R7 off oe", pad_oe[2], 0); chk("R7 off ie", pad_ie[2], 0);
        wr(2, 8'h90); chk("R7 input ie", pad_ie[2], 1);
        // R8 bias
        wr(3, 8'hA8); chk("R8 pulldown", pad_pd[3], 1); chk("R8 no pu", pad_pu[3], 0);
        wr(3, 8'hA6); chk("R8 pu str3", pad_pu_str[7:6], 3);
        wr(3, 8'hAA); chk("R8 no pull", int'(pad_pu[3]) + int'(pad_pd[3]), 0);
        // R9 fields
        wr(4, 8'hBC); chk("R9 drv", pad_drv[9:8], 3);
        wr(4, 8'hCE); chk("R9 func", pad_func[14:12], 7);
        wr(4, 8'h8B); chk("R9 vsel", pad_vsel[14:12], 5); chk("R9 en", pad_en[4], 1);
        // R10 inversion
        pad_in = 8'h20; tick(); chk("R10 inverted", core_in[5], 0);
        wr(5, 8'hD8); chk("R10 normal", core_in[5], 1);
        // R12 stores to banks 6/7 ignored
        wr(5, 8'hEF); wr(5, 8'hFF); wr(5, 8'h60); rd(BASE + 5, d); chk("R12 bank6 read", d, 8'h60);
        wr(5, 8'h70); rd(BASE + 5, d); chk("R4 bank7 read", d, 8'h70);
        wr(5, 8'h50); rd(BASE + 5, d); chk("R12 bank5 kept", d, 8'h58);
        // R1 out of range
        wr(NP, 8'h9F); rd(BASE + NP, d); chk("R1 above range", d, 0);
        rd(BASE - 1, d); chk("R1 below range", d, 0);
        // R5 read and write in the same cycle
        wr(6, 8'h95); wr(6, 8'h10);
        bus_addr = 10'(BASE + 6); bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h9A;
        tick(); bus_rd = 1'b0; bus_wr = 1'b0;
        chk("R5 old value", bus_rdata, 8'h15);
        rd(BASE + 6, d); chk("R5 new value", d, 8'h1A);
        // R2 store leaves pointer
        wr(6, 8'hC6); rd(BASE + 6, d); chk("R2 pointer kept", d, 8'h1A);

        // Random mixed traffic, concurrent reads and writes included
        for (int i = 0; i < 600; i++) begin
            bus_addr  = 10'(BASE - 1 + int'($urandom % (NP + 3)));
            bus_wdata = 8'($urandom);
            bus_wr    = 1'($urandom);
            bus_rd    = 1'($urandom);
            pad_in    = NP'($urandom);
            tick();
        end
        bus_wr = 1'b0; bus_rd = 1'b0;

        // R11 mid-run reset
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        rd(BASE + 1, d); chk("R11 read after reset", d, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule